// File: doc/BRIEF.md
# Two-Phase Accumulator Processor

A small 16-bit processor built around one accumulator, a 12-bit program counter and an instruction register. It runs programs from a single external memory, which it reaches through a 12-bit address bus, separate write and read data buses, a request strobe and a read/not-write line. The memory answers a read in the same cycle as the request, and it takes a write on the clock edge that closes the request cycle.

The control state is one bit that tells execute from fetch. The ALU does two jobs. It forms the accumulator result in an execute cycle, and it adds one to the fetch address in a fetch cycle. The new instruction is fetched in the last cycle of the current one. As a result, an instruction takes as many cycles as it makes memory accesses: two for the data-memory operations, one for the jumps. Once a stop instruction has been fetched, the processor makes no further accesses until it is reset.

Top module: `acc_cpu`

## Requirements
- R1: Reset is synchronous and active high. It clears the program counter through the ALU's zero output, clears the accumulator and selects the fetch phase. In the first cycle after reset is released, the processor reads address 0.
- R2: An instruction word carries the opcode in bits [15:12] and the operand address S in bits [11:0]. Opcode 0000 (load) copies the word read from S into the accumulator.
- R3: Opcode 0001 (store) drives the accumulator on the write-data bus with read/not-write low, at address S, for exactly one cycle. No other cycle ever writes.
- R4: Opcode 0010 adds the word at S to the accumulator, and opcode 0011 subtracts it. Both use 16-bit two's-complement wraparound.
- R5: Opcode 0100 (jump) takes one cycle, which fetches the next instruction from S and leaves the program counter at S+1.
- R6: Opcode 0101 jumps to S when accumulator bit 15 is 0. Otherwise the next fetch is sequential.
- R7: Opcode 0110 jumps to S when the accumulator is nonzero. Otherwise the next fetch is sequential.
- R8: Load, store, add and subtract each take exactly two cycles: an access to S, followed by a fetch.
- R9: A sequential fetch reads at the program counter, with the request high and read/not-write high. Every fetch leaves the program counter at the fetch address plus one.
- R10: Opcodes 0111 through 1111 stop the processor. From the cycle after the fetch onward, the request stays low, and the accumulator and program counter hold their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Write data; the accumulator during a store, otherwise zero |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_req | output | 1 | Memory request strobe |
| mem_rd_nwr | output | 1 | High for read, low for write |

## Verification
The assertions assume the memory returns the addressed word combinationally in the same cycle, and that a write lands on the edge that ends the request cycle. They also assume reset is held for at least one edge before the first checked cycle. The bench memory is a combinational array written on the clock edge, so it meets these assumptions exactly. The bench holds reset for several cycles, and it releases reset just after a rising edge. It only ever changes memory contents through the processor's own store cycles.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW  = 12,
  parameter int OPW = 4
) (
  input  logic                clk,
  input  logic                rst,
  output logic [AW-1:0]       mem_addr,
  output logic [AW+OPW-1:0]   mem_wdata,
  input  logic [AW+OPW-1:0]   mem_rdata,
  output logic                mem_req,
  output logic                mem_rd_nwr
);
  localparam int DW = AW + OPW;
  localparam logic [OPW-1:0] OP_LDA = OPW'(0);
  localparam logic [OPW-1:0] OP_STO = OPW'(1);
  localparam logic [OPW-1:0] OP_ADD = OPW'(2);
  localparam logic [OPW-1:0] OP_SUB = OPW'(3);
  localparam logic [OPW-1:0] OP_JMP = OPW'(4);
  localparam logic [OPW-1:0] OP_JGE = OPW'(5);
  localparam logic [OPW-1:0] OP_JNE = OPW'(6);

  typedef enum logic [2:0] {F_ZERO, F_PASS, F_ADD, F_SUB, F_INC} alu_fn_t;

  logic [AW-1:0]  pc;
  logic [DW-1:0]  acc, ir;
  logic           ex;

  logic [OPW-1:0] op;
  logic [AW-1:0]  opnd;
  logic           acc_neg, acc_zero, take, is_stop;
  logic           a_sel, b_sel, acc_ce, pc_ce, ir_ce, acc_oe, ex_next;
  alu_fn_t        alu_fn;
  logic [DW-1:0]  alu_b, alu_y;

  assign op       = ir[DW-1 -: OPW];
  assign opnd     = ir[AW-1:0];
  assign acc_neg  = acc[DW-1];
  assign acc_zero = (acc == '0);
  assign is_stop  = (op > OP_JNE);
  assign take     = (op == OP_JMP) | ((op == OP_JGE) & ~acc_neg) | ((op == OP_JNE) & ~acc_zero);

  assign a_sel   = ex | take;
  assign b_sel   = ex;
  assign acc_ce  = ex & (op != OP_STO);
  assign pc_ce   = ~ex & ~is_stop;
  assign ir_ce   = ~ex & ~is_stop;
  assign acc_oe  = ex & (op == OP_STO);
  assign ex_next = ir_ce & (mem_rdata[DW-1 -: OPW] <= OP_SUB);

  always_comb begin
    if (rst)                alu_fn = F_ZERO;
    else if (!ex)           alu_fn = F_INC;
    else if (op == OP_ADD)  alu_fn = F_ADD;
    else if (op == OP_SUB)  alu_fn = F_SUB;
    else                    alu_fn = F_PASS;
  end

  assign alu_b = b_sel ? mem_rdata : DW'(mem_addr);

  always_comb begin
    case (alu_fn)
      F_PASS:  alu_y = alu_b;
      F_ADD:   alu_y = acc + alu_b;
      F_SUB:   alu_y = acc - alu_b;
      F_INC:   alu_y = alu_b + DW'(1);
      default: alu_y = '0;
    endcase
  end

  assign mem_addr   = a_sel ? opnd : pc;
  assign mem_req    = ex | ~is_stop;
  assign mem_rd_nwr = ~acc_oe;
  assign mem_wdata  = acc_oe ? acc : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= alu_y[AW-1:0];
      acc <= '0;
      ir  <= '0;
      ex  <= 1'b0;
    end else begin
      if (pc_ce)  pc  <= alu_y[AW-1:0];
      if (ir_ce)  ir  <= mem_rdata;
      if (acc_ce) acc <= alu_y;
      ex <= ex_next;
    end
  end

  assert_fetch_inc_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !ex) |=> (pc == $past(mem_addr) + AW'(1)));

  assert_jump_target_R5: assert property (@(posedge clk) disable iff (rst)
    (!ex && op == OP_JMP) |=> (pc == $past(opnd) + AW'(1)));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ex && op == OP_LDA) |=> (acc == $past(mem_rdata)));

  assert_add_R4: assert property (@(posedge clk) disable iff (rst)
    (ex && op == OP_ADD) |=> (acc == $past(acc) + $past(mem_rdata)));

  assert_sub_R4: assert property (@(posedge clk) disable iff (rst)
    (ex && op == OP_SUB) |=> (acc == $past(acc) - $past(mem_rdata)));

  assert_store_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rd_nwr) |-> (ex && mem_wdata == acc && mem_addr == opnd));

  assert_two_phase_R8: assert property (@(posedge clk) disable iff (rst)
    ex |=> !ex);

  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ex && is_stop) |=> (!mem_req && $stable(pc) && $stable(acc)));
endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_req, mem_rd_nwr;

  always #2.5 clk = ~clk;

  acc_cpu u_dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                 .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_rd_nwr(mem_rd_nwr));

  logic [15:0] mem [0:255];
  logic [15:0] mm  [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_req && !mem_rd_nwr) mem[mem_addr[7:0]] <= mem_wdata;

  typedef struct packed {
    logic        req;
    logic        rnw;
    logic [11:0] addr;
    logic [15:0] wd;
    logic [3:0]  tag;
  } item_t;

  item_t q[$];
  int    tests = 0, fails = 0;
  bit    active = 0, done = 0;

  function automatic string tname(input logic [3:0] t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic load_prog();
    logic [15:0] p [0:18];
    p = '{16'h0040, 16'h2041, 16'h500A, 16'h3042, 16'h600A, 16'h5007, 16'h7000,
          16'h1050, 16'h3043, 16'h600C, 16'h7000, 16'h7000, 16'h1051, 16'h2043,
          16'h4010, 16'hF000, 16'h0044, 16'h1052, 16'hB123};
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    for (int i = 0; i < 19; i++) mem[i] = p[i];
    mem[8'h40] = 16'h0005; mem[8'h41] = 16'h7FFE; mem[8'h42] = 16'h8003;
    mem[8'h43] = 16'h0001; mem[8'h44] = 16'h1234;
    for (int i = 0; i < 256; i++) mm[i] = mem[i];
  endtask

  task automatic push(input logic req, input logic rnw, input logic [11:0] a,
                      input logic [15:0] w, input logic [3:0] t);
    item_t it;
    it.req = req; it.rnw = rnw; it.addr = a; it.wd = w; it.tag = t;
    q.push_back(it);
  endtask

  task automatic build_expected();
    logic [11:0] nxt, pcm, s;
    logic [15:0] acc, ins;
    logic [3:0]  ftag, op;
    nxt = 12'h0; acc = 16'h0; ftag = 4'd1;
    for (int step = 0; step < 100; step++) begin
      push(1'b1, 1'b1, nxt, 16'h0, ftag);
      ins = mm[nxt[7:0]]; pcm = nxt + 12'd1; op = ins[15:12]; s = ins[11:0];
      ftag = 4'd9;
      if (op <= 4'd3) begin
        case (op)
          4'd0: begin push(1'b1, 1'b1, s, 16'h0, 4'd2); acc = mm[s[7:0]]; end
          4'd1: begin push(1'b1, 1'b0, s, acc, 4'd3); mm[s[7:0]] = acc; end
          4'd2: begin push(1'b1, 1'b1, s, 16'h0, 4'd4); acc = acc + mm[s[7:0]]; end
          default: begin push(1'b1, 1'b1, s, 16'h0, 4'd4); acc = acc - mm[s[7:0]]; end
        endcase
        nxt = pcm; ftag = 4'd8;
      end else if (op == 4'd4) begin
        nxt = s; ftag = 4'd5;
      end else if (op == 4'd5) begin
        nxt = acc[15] ? pcm : s; ftag = 4'd6;
      end else if (op == 4'd6) begin
        nxt = (acc != 16'h0) ? s : pcm; ftag = 4'd7;
      end else begin
        for (int k = 0; k < 8; k++) push(1'b0, 1'b1, 12'h0, 16'h0, 4'd10);
        break;
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (active && q.size() != 0) begin
        item_t e;
        logic ok;
        e = q.pop_front();
        ok = (mem_req === e.req);
        if (e.req) ok = ok && (mem_addr === e.addr) && (mem_rd_nwr === e.rnw)
                        && (e.rnw || mem_wdata === e.wd);
        tests++;
        if (!ok) begin
          fails++;
          $display("FAIL %s: got req=%b addr=%h rnw=%b wd=%h, expected req=%b addr=%h rnw=%b wd=%h",
                   tname(e.tag), mem_req, mem_addr, mem_rd_nwr, mem_wdata,
                   e.req, e.addr, e.rnw, e.wd);
        end
      end
    end
  end

  task automatic run_once();
    load_prog();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    build_expected();
    rst = 1'b0;
    active = 1;
    while (q.size() != 0) @(posedge clk);
    @(posedge clk);
    active = 0;
    for (int i = 0; i < 256; i++) begin
      if (i >= 8'h50 && i <= 8'h52) begin
        tests++;
        if (mem[i] !== mm[i]) begin
          fails++;
          $display("FAIL R3: mem[%h] got %h expected %h", i, mem[i], mm[i]);
        end
      end
    end
  endtask

  initial begin
    run_once();
    run_once();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule